// File: doc/BRIEF.md
# Two-Phase Branch Predictor with Dispatch Override

This block steers instruction fetch in two steps. At fetch, a small two-way target cache is looked up with the current fetch address. The cache holds only branches that were seen taken. The next fetch address comes out one cycle later: the cached target on a hit, otherwise the start of the next aligned 16-byte fetch group.

Later, at dispatch, each decoded conditional branch is predicted again. The second prediction uses a larger table of two-bit saturating counters. If the branch's condition is already known, the known condition is used instead of the counter. When this final direction differs from what fetch assumed, the block raises a one-cycle redirect that carries the corrected fetch address. The branch execution unit trains both tables through an update port.

All three ports are valid-only streams. The block always accepts input, so there is no ready signal and no back-pressure. Each accepted fetch or dispatch beat produces exactly one result beat on the following cycle. Flushing the pipeline on a redirect is the job of the consumer.

Top module: `twophase_bpred`

## Requirements
- R1: Each cycle with `fetch_valid` high produces `fetch_out_valid` high on the next cycle, together with `fetch_next_pc` and `fetch_hit`. A cycle without `fetch_valid` produces no result.
- R2: The target cache uses set index PC[8:2] (128 sets, 2 ways) and tag PC[31:9]. On a hit, `fetch_next_pc` is the stored target and `fetch_hit` is 1. On a miss, `fetch_next_pc` is (fetch_pc & ~15) + 16 and `fetch_hit` is 0.
- R3: An update with `upd_taken`=1 writes `upd_target` into the entry for `upd_pc`: a hit rewrites that way, a miss allocates a way. An update with `upd_taken`=0 that hits invalidates that way. An update with `upd_taken`=0 that misses leaves the cache unchanged.
- R4: On allocation, the victim is the first invalid way (way 0 before way 1). If both ways are valid, the way named by the per-set replacement bit is chosen. A taken hit or a fill sets that bit to the other way. An invalidation leaves the bit unchanged.
- R5: The direction table holds 2048 two-bit counters indexed by PC[12:2], all reset to 1. Every update moves its counter up on taken and down on not-taken, saturating at 0 and 3. A value of 2 or 3 predicts taken.
- R6: When `dsp_ops_ready` is 1, the dispatch direction `dsp_taken` equals `dsp_cond` and the counter is ignored.
- R7: One cycle after `dsp_valid`, `dsp_out_valid` is 1 and `dsp_taken` gives the final direction. `redirect_valid` is 1 exactly when that direction differs from `dsp_fetch_taken`. `redirect_pc` is then `dsp_target` if the final direction is taken, and `dsp_pc`+4 otherwise.
- R8: When a lookup (fetch or dispatch) and an update fall in the same cycle, the lookup sees the table contents from before that update.
- R9: After reset, no output valid is raised until an input beat arrives. Every cache way is invalid and every counter holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch lookup beat |
| fetch_pc | input | 32 | Fetch address |
| fetch_out_valid | output | 1 | Lookup result beat |
| fetch_hit | output | 1 | Target cache hit |
| fetch_next_pc | output | 32 | Next fetch address |
| dsp_valid | input | 1 | Dispatch check beat |
| dsp_pc | input | 32 | Branch address |
| dsp_fetch_taken | input | 1 | Direction assumed at fetch |
| dsp_target | input | 32 | Branch target |
| dsp_ops_ready | input | 1 | Condition operands available |
| dsp_cond | input | 1 | Resolved condition (taken) |
| dsp_out_valid | output | 1 | Dispatch result beat |
| dsp_taken | output | 1 | Final direction |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Corrected fetch address |
| upd_valid | input | 1 | Training beat |
| upd_pc | input | 32 | Resolved branch address |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |

## Verification
A fetch lookup and a training write can hit the same target-cache set in the same cycle. A dispatch read and a counter update can also hit the same counter in the same cycle. Both cases are provoked by random traffic that draws every address from a pool of two sets and three tags. A directed case adds a taken update and a fetch of the same address in one cycle, followed by a repeat fetch. The bench judges the results with a reference model. For each beat, the model computes the expected outputs from its state before that cycle's update, and only then applies the update.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  localparam int unsigned GROUP_BYTES = 16;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    else    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken
);
  import bpred_pkg::*;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [1:0] ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'd1;
    end else if (up_valid) begin
      ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
    end
  end

  // R5
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && ctr_q[up_idx] == 2'd3) |=> ctr_q[$past(up_idx)] == 2'd3);
endmodule

// File: rtl/bp_tgt_cache.sv
module bp_tgt_cache #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-3:0] lk_word,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  input  logic          up_valid,
  input  logic [AW-3:0] up_word,
  input  logic          up_taken,
  input  logic [AW-1:0] up_target
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned TAG_W = AW - 2 - IDX_W;
  localparam int unsigned WAYS  = 2;

  logic             vld_q [WAYS][SETS];
  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [AW-1:0]    tgt_q [WAYS][SETS];
  logic             lru_q [SETS];

  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_hv, up_hv;
  logic             up_way, victim;

  assign lk_set = lk_word[IDX_W-1:0];
  assign lk_tag = lk_word[AW-3:IDX_W];
  assign up_set = up_word[IDX_W-1:0];
  assign up_tag = up_word[AW-3:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hv[w] = vld_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    assign up_hv[w] = vld_q[w][up_set] && (tag_q[w][up_set] == up_tag);
  end

  always_comb begin
    lk_hit    = |lk_hv;
    lk_target = lk_hv[1] ? tgt_q[1][lk_set] : tgt_q[0][lk_set];
    if (!vld_q[0][up_set])      victim = 1'b0;
    else if (!vld_q[1][up_set]) victim = 1'b1;
    else                        victim = lru_q[up_set];
    up_way = (|up_hv) ? up_hv[1] : victim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) vld_q[w][s] <= 1'b0;
      end
    end else if (up_valid) begin
      if (up_taken) begin
        vld_q[up_way][up_set] <= 1'b1;
        lru_q[up_set]         <= ~up_way;
      end else if (|up_hv) begin
        vld_q[up_hv[1]][up_set] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_taken) begin
      tag_q[up_way][up_set] <= up_tag;
      tgt_q[up_way][up_set] <= up_target;
    end
  end

  // R4
  uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(up_hv));
  // R3
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |=> up_hv[$past(up_way)] || (up_word != $past(up_word)));
endmodule

// File: rtl/twophase_bpred.sv
module twophase_bpred #(
  parameter int unsigned AW        = 32,
  parameter int unsigned TC_IDX_W  = 7,
  parameter int unsigned DIR_IDX_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          fetch_out_valid,
  output logic          fetch_hit,
  output logic [AW-1:0] fetch_next_pc,
  input  logic          dsp_valid,
  input  logic [AW-1:0] dsp_pc,
  input  logic          dsp_fetch_taken,
  input  logic [AW-1:0] dsp_target,
  input  logic          dsp_ops_ready,
  input  logic          dsp_cond,
  output logic          dsp_out_valid,
  output logic          dsp_taken,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target
);
  import bpred_pkg::*;
  localparam logic [AW-1:0] GRP      = AW'(GROUP_BYTES);
  localparam logic [AW-1:0] GRP_MASK = ~(GRP - 1'b1);

  logic          tc_hit;
  logic [AW-1:0] tc_tgt;
  logic [1:0]    dctr;
  logic          dir_now;
  logic          unused_lowbits;

  assign unused_lowbits = ^{upd_pc[1:0], fetch_pc[1:0] & 2'b00};

  bp_tgt_cache #(.AW(AW), .IDX_W(TC_IDX_W)) tc_i (
    .clk(clk), .rst_n(rst_n),
    .lk_word(fetch_pc[AW-1:2]), .lk_hit(tc_hit), .lk_target(tc_tgt),
    .up_valid(upd_valid), .up_word(upd_pc[AW-1:2]),
    .up_taken(upd_taken), .up_target(upd_target)
  );

  bp_dir_table #(.IDX_W(DIR_IDX_W)) dt_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(dsp_pc[DIR_IDX_W+1:2]), .rd_ctr(dctr),
    .up_valid(upd_valid), .up_idx(upd_pc[DIR_IDX_W+1:2]), .up_taken(upd_taken)
  );

  assign dir_now = dsp_ops_ready ? dsp_cond : dctr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_out_valid <= 1'b0;
      fetch_hit       <= 1'b0;
      fetch_next_pc   <= '0;
      dsp_out_valid   <= 1'b0;
      dsp_taken       <= 1'b0;
      redirect_valid  <= 1'b0;
      redirect_pc     <= '0;
    end else begin
      fetch_out_valid <= fetch_valid;
      if (fetch_valid) begin
        fetch_hit     <= tc_hit;
        fetch_next_pc <= tc_hit ? tc_tgt : (fetch_pc & GRP_MASK) + GRP;
      end
      dsp_out_valid  <= dsp_valid;
      redirect_valid <= dsp_valid && (dir_now != dsp_fetch_taken);
      if (dsp_valid) begin
        dsp_taken   <= dir_now;
        redirect_pc <= dir_now ? dsp_target : dsp_pc + AW'(4);
      end
    end
  end

  // R1
  fetch_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_out_valid |-> $past(fetch_valid));
  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_out_valid && !fetch_hit) |-> fetch_next_pc == (($past(fetch_pc) & GRP_MASK) + GRP));
  // R6
  resolved_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_out_valid && $past(dsp_ops_ready)) |-> dsp_taken == $past(dsp_cond));
  // R7
  redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (dsp_out_valid && dsp_taken != $past(dsp_fetch_taken)));
endmodule

// File: tb/twophase_bpred_tb.sv
module twophase_bpred_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        fetch_valid = 0, fetch_out_valid, fetch_hit;
  logic [31:0] fetch_pc = 0, fetch_next_pc;
  logic        dsp_valid = 0, dsp_fetch_taken = 0, dsp_ops_ready = 0, dsp_cond = 0;
  logic [31:0] dsp_pc = 0, dsp_target = 0, redirect_pc;
  logic        dsp_out_valid, dsp_taken, redirect_valid;
  logic        upd_valid = 0, upd_taken = 0;
  logic [31:0] upd_pc = 0, upd_target = 0;

  twophase_bpred dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;

  bit [1:0]  m_ctr [2048];
  bit        m_v   [2][128];
  bit [22:0] m_tag [2][128];
  bit [31:0] m_tgt [2][128];
  bit        m_lru [128];

  bit pf = 0, pf_hit = 0, pd = 0, pd_dir = 0, pd_red = 0;
  bit [31:0] pf_npc = 0, pd_rpc = 0;
  string pf_req = "R2", pd_req = "R7";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_pending();
    chk(fetch_out_valid == pf, "R1", "fetch_out_valid", 32'(fetch_out_valid), 32'(pf));
    if (pf) begin
      chk(fetch_hit == pf_hit, pf_req, "fetch_hit", 32'(fetch_hit), 32'(pf_hit));
      chk(fetch_next_pc == pf_npc, pf_req, "fetch_next_pc", fetch_next_pc, pf_npc);
    end
    chk(dsp_out_valid == pd, "R7", "dsp_out_valid", 32'(dsp_out_valid), 32'(pd));
    chk(redirect_valid == pd_red, pd_req, "redirect_valid", 32'(redirect_valid), 32'(pd_red));
    if (pd) chk(dsp_taken == pd_dir, pd_req, "dsp_taken", 32'(dsp_taken), 32'(pd_dir));
    if (pd_red) chk(redirect_pc == pd_rpc, pd_req, "redirect_pc", redirect_pc, pd_rpc);
  endtask

  task automatic step(input bit fv, input bit [31:0] fpc,
                      input bit dv, input bit [31:0] dpc, input bit dft, input bit [31:0] dtg,
                      input bit dops, input bit dcnd,
                      input bit uv, input bit [31:0] upc, input bit ut, input bit [31:0] utg,
                      input string freq, input string dreq);
    bit [6:0] s;
    bit [22:0] t;
    bit h0, h1, w;
    @(negedge clk);
    check_pending();
    // expected fetch result from pre-update state (R2, R8)
    s = fpc[8:2]; t = fpc[31:9];
    h0 = m_v[0][s] && m_tag[0][s] == t;
    h1 = m_v[1][s] && m_tag[1][s] == t;
    pf = fv; pf_hit = h0 | h1; pf_req = freq;
    pf_npc = h1 ? m_tgt[1][s] : h0 ? m_tgt[0][s] : (fpc & 32'hFFFF_FFF0) + 32'd16;
    // expected dispatch result (R5, R6, R7)
    pd = dv; pd_req = dreq;
    pd_dir = dops ? dcnd : m_ctr[dpc[12:2]][1];
    pd_red = dv && (pd_dir != dft);
    pd_rpc = pd_dir ? dtg : dpc + 32'd4;
    // model update (R3, R4, R5)
    if (uv) begin
      if (ut && m_ctr[upc[12:2]] != 2'd3) m_ctr[upc[12:2]]++;
      if (!ut && m_ctr[upc[12:2]] != 2'd0) m_ctr[upc[12:2]]--;
      s = upc[8:2]; t = upc[31:9];
      h0 = m_v[0][s] && m_tag[0][s] == t;
      h1 = m_v[1][s] && m_tag[1][s] == t;
      if (ut) begin
        if (h0 | h1) w = h1;
        else if (!m_v[0][s]) w = 0;
        else if (!m_v[1][s]) w = 1;
        else w = m_lru[s];
        m_v[w][s] = 1; m_tag[w][s] = t; m_tgt[w][s] = utg; m_lru[s] = ~w;
      end else if (h0 | h1) begin
        m_v[h1][s] = 0;
      end
    end
    fetch_valid = fv; fetch_pc = fpc;
    dsp_valid = dv; dsp_pc = dpc; dsp_fetch_taken = dft; dsp_target = dtg;
    dsp_ops_ready = dops; dsp_cond = dcnd;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
  endtask

  function automatic bit [31:0] pool_pc(input int r);
    bit [31:0] tg;
    bit [31:0] st;
    tg = 32'h100 + 32'h100 * 32'(r % 3);
    st = ((r / 3) % 2 == 0) ? 32'd5 : 32'd6;
    return (tg << 9) | (st << 2);
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) m_ctr[i] = 2'd1;
    for (int s = 0; s < 128; s++) begin
      m_lru[s] = 0; m_v[0][s] = 0; m_v[1][s] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    chk(!fetch_out_valid && !dsp_out_valid && !redirect_valid, "R9", "idle outputs",
        {29'd0, fetch_out_valid, dsp_out_valid, redirect_valid}, 32'd0);
    // R2/R9: miss on empty cache, unaligned address falls through to next group
    step(1, 32'h0002_0014, 1, 32'h0002_0014, 0, 32'h0, 0, 0, 0, 0, 0, 0, "R2", "R9");
    // R8: taken update and fetch/dispatch to the same address in one cycle see old state
    step(1, 32'h0002_0014, 1, 32'h0002_0014, 1, 32'h0000_4000, 0, 0,
         1, 32'h0002_0014, 1, 32'h0000_4000, "R8", "R8");
    step(1, 32'h0002_0014, 1, 32'h0002_0014, 1, 32'h0000_4000, 0, 0, 0, 0, 0, 0, "R3", "R5");
    // R5: saturation then single decrement keeps taken
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0002_0014, 1, 32'h0000_4000, "R5", "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0002_0014, 0, 0, "R5", "R5");
    step(1, 32'h0002_0014, 1, 32'h0002_0014, 0, 32'h0000_4000, 0, 0, 0, 0, 0, 0, "R3", "R5");
    // R6: known condition overrides counter (not taken despite counter=2)
    step(0, 0, 1, 32'h0002_0014, 1, 32'h0000_4000, 1, 0, 0, 0, 0, 0, "R2", "R6");
    step(0, 0, 1, 32'h0003_0000, 0, 32'h0000_8888, 1, 1, 0, 0, 0, 0, "R2", "R6");
    // R4: three tags into one set force replacement
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, pool_pc(0), 1, 32'hA0, "R4", "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, pool_pc(1), 1, 32'hB0, "R4", "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, pool_pc(2), 1, 32'hC0, "R4", "R4");
    step(1, pool_pc(0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4", "R4");
    step(1, pool_pc(1), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4", "R4");
    step(1, pool_pc(2), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4", "R4");
    // R3: not-taken hit invalidates
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, pool_pc(2), 0, 0, "R3", "R3");
    step(1, pool_pc(2), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3", "R3");
    // random mix; same-set and same-counter collisions are frequent (R8)
    for (int n = 0; n < 6000; n++) begin
      int a, b, c;
      a = int'($urandom % 6); b = int'($urandom % 6); c = int'($urandom % 6);
      step($urandom % 4 != 0, pool_pc(a) + 32'(($urandom % 2) * 16),
           $urandom % 3 != 0, pool_pc(b), 1'($urandom), 32'($urandom % 65536) << 2,
           1'($urandom % 3 == 0), 1'($urandom),
           $urandom % 2 == 0, pool_pc(c), 1'($urandom % 3 != 0), 32'($urandom % 65536) << 2,
           "R8", "R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1", "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1", "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule